// File: doc/BRIEF.md
# Root Port Reset Bring-Up Sequencer

This block takes a PCIe root-port controller from reset to link training. It runs a fixed series of steps. First it puts every controller reset under its own control and asserts all of them. It then turns link training off and writes the root-complex device type. It holds the fundamental reset (PERST#) for a counted time. After that it brings up the auxiliary power detect and the three bus clock domains, and releases the remaining resets. It then opens a short window in which read-only capability and class-code fields may be written. Link training is enabled as the last step.

A single `start_i` pulse launches the series. The block ignores `start_i` while a series is running. `done_o` pulses for one cycle when link training is enabled. The PERST# hold length is `HOLD_MS` milliseconds of `TICKS_PER_MS` clock ticks each. Every other step lasts exactly one clock. All outputs are registered, so each step's effect appears one clock after the sequencer enters that step. A later `start_i` after `done_o` runs the whole series again from the reset-assert step.

Top module: `rp_boot_seq`

## Requirements
- R1: While `rst_n` is low and after its release, all four reset lines are 0 (asserted) and `rst_sel_o` is 0. `aux_pwr_det_o`, `clk_req_o`, `ro_wr_en_o` and `link_en_o` are 0, and `clk_stop_o` is all ones. `dev_type_o`, `cap_width_o`, `cap_speed_o`, `class_code_o` and `done_o` are 0.
- R2: Take the rising clock edge that samples `start_i` high in idle as edge 0. At edge 1, all four reset lines go to 0 and `rst_sel_o` goes to 1. At the same edge, all clock requests drop, all clock stops go to 1 and the auxiliary power detect drops.
- R3: `link_en_o` is 0 from edge 2. `dev_type_o` becomes 4 (root complex) at edge 3, before PERST# is released.
- R4: With H = `HOLD_MS`*`TICKS_PER_MS`, `perst_in_n_o` rises at edge 4+H and `perst_out_n_o` rises at edge 5+H. PERST# is therefore held for no fewer than H cycles.
- R5: `aux_pwr_det_o` rises at edge 6+H, after PERST# is released.
- R6: Clock domains are handled in the order bit 0 (master), bit 1 (slave), bit 2 (register port). For each domain, `clk_req_o` bit d rises at edge 7+H+2d, and `clk_stop_o` bit d falls one edge later.
- R7: `pwup_rst_n_o` rises at edge 13+H and `btn_rst_n_o` rises at edge 14+H, both after all clocks run.
- R8: `ro_wr_en_o` rises at edge 15+H. `cap_width_o` becomes `LANES` (4) at 16+H, `cap_speed_o` becomes `MAX_SPEED` (2) at 17+H and `class_code_o` becomes 0x060400 at 18+H. `ro_wr_en_o` falls at 19+H. These three fields never change while `ro_wr_en_o` is 0.
- R9: `link_en_o` rises at edge 20+H, the last step. `done_o` is 1 for exactly the one cycle after that edge.
- R10: `start_i` pulses that arrive while a series is running leave every output's timing unchanged.
- R11: A `start_i` after completion reruns the series with the same timing. `link_en_o` drops at edge 2, and fields already written keep their values until rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch the bring-up series (sampled in idle only) |
| done_o | output | 1 | One-cycle pulse when link training is enabled |
| perst_in_n_o | output | 1 | Fundamental reset toward the controller core, active low |
| perst_out_n_o | output | 1 | Fundamental reset toward the slot, active low |
| pwup_rst_n_o | output | 1 | Power-up reset, active low |
| btn_rst_n_o | output | 1 | Button reset, active low |
| rst_sel_o | output | 1 | 1: resets driven by this sequencer |
| aux_pwr_det_o | output | 1 | Auxiliary power detect |
| clk_req_o | output | 3 | Clock request per domain (0 master, 1 slave, 2 register port) |
| clk_stop_o | output | 3 | Clock stop per domain |
| dev_type_o | output | 4 | Device-type field |
| ro_wr_en_o | output | 1 | Write enable for read-only fields |
| cap_width_o | output | 4 | Maximum link width capability |
| cap_speed_o | output | 4 | Maximum link speed capability |
| class_code_o | output | 24 | Class code {base, subclass, interface} |
| link_en_o | output | 1 | Link training enable |

## Verification
Every output's due edge is a fixed offset from the edge that samples `start_i`. The offsets are 1 to 3 before the hold, 4+H through 20+H after it, and 21+H for the `done_o` fall. The bench counts edges from that sample. After each edge it advances a step model by the step due at that count. It then compares all outputs, packed together, half a period later, so every cycle of each series is checked at the exact edge its value is due. Three series are run with a short hold. The second series injects mid-run `start_i` pulses, including one inside the hold. The third series is a plain restart.

// File: rtl/rp_boot_pkg.sv
package rp_boot_pkg;
  localparam int NDOM = 3;

  // Encoding order is the execution order; the FSM advances by +1.
  typedef enum logic [4:0] {
    ST_IDLE, ST_ASSERT, ST_LTSSM_OFF, ST_DEVTYPE, ST_HOLD,
    ST_PERST_IN, ST_PERST_OUT, ST_AUX,
    ST_CREQ_M, ST_CSTOP_M, ST_CREQ_S, ST_CSTOP_S, ST_CREQ_D, ST_CSTOP_D,
    ST_PWUP, ST_BTN, ST_WE_ON, ST_WIDTH, ST_SPEED, ST_CLASS, ST_WE_OFF,
    ST_LINK
  } step_e;
endpackage

// File: rtl/rp_hold_timer.sv
module rp_hold_timer #(
  parameter int unsigned HOLD_CYC = 7500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expire_o
);
  localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb cnt_d = run_i ? cnt_q + 1'b1 : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/rp_step_fsm.sv
module rp_step_fsm
  import rp_boot_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start_i,
  input  logic  expire_i,
  output step_e step_o,
  output logic  hold_o
);
  step_e step_q, step_d;

  always_comb begin
    unique case (step_q)
      ST_IDLE: step_d = start_i  ? ST_ASSERT   : ST_IDLE;
      ST_HOLD: step_d = expire_i ? ST_PERST_IN : ST_HOLD;
      ST_LINK: step_d = ST_IDLE;
      default: step_d = step_e'(step_q + 5'd1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= ST_IDLE;
    else        step_q <= step_d;
  end

  assign step_o = step_q;
  assign hold_o = (step_q == ST_HOLD);
endmodule

// File: rtl/rp_ctl_bank.sv
module rp_ctl_bank
  import rp_boot_pkg::*;
#(
  parameter logic [3:0]  DEV_TYPE  = 4'd4,
  parameter logic [3:0]  LANES     = 4'd4,
  parameter logic [3:0]  MAX_SPEED = 4'd2,
  parameter logic [23:0] CLASS     = 24'h060400
) (
  input  logic            clk,
  input  logic            rst_n,
  input  step_e           step_i,
  output logic            done_o,
  output logic            perst_in_n_o,
  output logic            perst_out_n_o,
  output logic            pwup_rst_n_o,
  output logic            btn_rst_n_o,
  output logic            rst_sel_o,
  output logic            aux_pwr_det_o,
  output logic [NDOM-1:0] clk_req_o,
  output logic [NDOM-1:0] clk_stop_o,
  output logic [3:0]      dev_type_o,
  output logic            ro_wr_en_o,
  output logic [3:0]      cap_width_o,
  output logic [3:0]      cap_speed_o,
  output logic [23:0]     class_code_o,
  output logic            link_en_o
);
  logic go;
  assign go = (step_i == ST_ASSERT);

  // reset lines and select
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perst_in_n_o  <= 1'b0;
      perst_out_n_o <= 1'b0;
      pwup_rst_n_o  <= 1'b0;
      btn_rst_n_o   <= 1'b0;
      rst_sel_o     <= 1'b0;
      aux_pwr_det_o <= 1'b0;
    end else if (go) begin
      perst_in_n_o  <= 1'b0;
      perst_out_n_o <= 1'b0;
      pwup_rst_n_o  <= 1'b0;
      btn_rst_n_o   <= 1'b0;
      rst_sel_o     <= 1'b1;
      aux_pwr_det_o <= 1'b0;
    end else begin
      if (step_i == ST_PERST_IN)  perst_in_n_o  <= 1'b1;
      if (step_i == ST_PERST_OUT) perst_out_n_o <= 1'b1;
      if (step_i == ST_AUX)       aux_pwr_det_o <= 1'b1;
      if (step_i == ST_PWUP)      pwup_rst_n_o  <= 1'b1;
      if (step_i == ST_BTN)       btn_rst_n_o   <= 1'b1;
    end
  end

  // per-domain clock request then clock stop release
  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    localparam step_e REQ_ST = step_e'(5'(int'(ST_CREQ_M) + 2*d));
    localparam step_e STP_ST = step_e'(5'(int'(ST_CREQ_M) + 2*d + 1));
    logic req_q, stop_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        req_q  <= 1'b0;
        stop_q <= 1'b1;
      end else if (go) begin
        req_q  <= 1'b0;
        stop_q <= 1'b1;
      end else begin
        if (step_i == REQ_ST) req_q  <= 1'b1;
        if (step_i == STP_ST) stop_q <= 1'b0;
      end
    end
    assign clk_req_o[d]  = req_q;
    assign clk_stop_o[d] = stop_q;
  end

  // configuration fields and write window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_type_o   <= '0;
      ro_wr_en_o   <= 1'b0;
      cap_width_o  <= '0;
      cap_speed_o  <= '0;
      class_code_o <= '0;
    end else begin
      if (step_i == ST_DEVTYPE) dev_type_o   <= DEV_TYPE;
      if (step_i == ST_WE_ON)   ro_wr_en_o   <= 1'b1;
      if (step_i == ST_WE_OFF)  ro_wr_en_o   <= 1'b0;
      if (step_i == ST_WIDTH)   cap_width_o  <= LANES;
      if (step_i == ST_SPEED)   cap_speed_o  <= MAX_SPEED;
      if (step_i == ST_CLASS)   class_code_o <= CLASS;
    end
  end

  // link enable and completion pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_en_o <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      if (step_i == ST_LTSSM_OFF)            link_en_o <= 1'b0;
      else if (step_i == ST_LINK && !link_en_o) link_en_o <= 1'b1;
      done_o <= (step_i == ST_LINK);
    end
  end
endmodule

// File: rtl/rp_boot_seq.sv
module rp_boot_seq
  import rp_boot_pkg::*;
#(
  parameter int unsigned TICKS_PER_MS = 50000,
  parameter int unsigned HOLD_MS      = 150,
  parameter logic [3:0]  DEV_TYPE     = 4'd4,
  parameter logic [3:0]  LANES        = 4'd4,
  parameter logic [3:0]  MAX_SPEED    = 4'd2,
  parameter logic [23:0] CLASS        = 24'h060400
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  output logic        done_o,
  output logic        perst_in_n_o,
  output logic        perst_out_n_o,
  output logic        pwup_rst_n_o,
  output logic        btn_rst_n_o,
  output logic        rst_sel_o,
  output logic        aux_pwr_det_o,
  output logic [2:0]  clk_req_o,
  output logic [2:0]  clk_stop_o,
  output logic [3:0]  dev_type_o,
  output logic        ro_wr_en_o,
  output logic [3:0]  cap_width_o,
  output logic [3:0]  cap_speed_o,
  output logic [23:0] class_code_o,
  output logic        link_en_o
);
  localparam int unsigned HOLD_CYC = TICKS_PER_MS * HOLD_MS;

  step_e step;
  logic  hold, expire;

  rp_step_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .expire_i(expire),
    .step_o(step), .hold_o(hold)
  );

  rp_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run_i(hold), .expire_o(expire)
  );

  rp_ctl_bank #(
    .DEV_TYPE(DEV_TYPE), .LANES(LANES), .MAX_SPEED(MAX_SPEED), .CLASS(CLASS)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .step_i(step), .done_o(done_o),
    .perst_in_n_o(perst_in_n_o), .perst_out_n_o(perst_out_n_o),
    .pwup_rst_n_o(pwup_rst_n_o), .btn_rst_n_o(btn_rst_n_o),
    .rst_sel_o(rst_sel_o), .aux_pwr_det_o(aux_pwr_det_o),
    .clk_req_o(clk_req_o), .clk_stop_o(clk_stop_o),
    .dev_type_o(dev_type_o), .ro_wr_en_o(ro_wr_en_o),
    .cap_width_o(cap_width_o), .cap_speed_o(cap_speed_o),
    .class_code_o(class_code_o), .link_en_o(link_en_o)
  );
endmodule

// File: rtl/rp_boot_chk.sv
module rp_boot_chk #(
  parameter int unsigned HOLD_CYC = 7500000,
  parameter logic [3:0]  DEV_TYPE = 4'd4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        done_o,
  input logic        perst_in_n_o,
  input logic        perst_out_n_o,
  input logic        pwup_rst_n_o,
  input logic        btn_rst_n_o,
  input logic        aux_pwr_det_o,
  input logic [2:0]  clk_req_o,
  input logic [2:0]  clk_stop_o,
  input logic [3:0]  dev_type_o,
  input logic        ro_wr_en_o,
  input logic [3:0]  cap_width_o,
  input logic [3:0]  cap_speed_o,
  input logic [23:0] class_code_o,
  input logic        link_en_o
);
  int unsigned low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         low_cnt <= 0;
    else if (perst_out_n_o)             low_cnt <= 0;
    else if (low_cnt < HOLD_CYC)        low_cnt <= low_cnt + 1;
  end

  assert_perst_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(perst_out_n_o) |-> (low_cnt >= HOLD_CYC));

  assert_devtype_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(perst_in_n_o) |-> (dev_type_o == DEV_TYPE));

  assert_aux_after_perst_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aux_pwr_det_o) |-> perst_out_n_o);

  for (genvar d = 0; d < 3; d++) begin : g_clk
    assert_stop_after_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_stop_o[d]) |-> clk_req_o[d]);
  end

  assert_domain_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_req_o[1]) |-> !clk_stop_o[0]);

  assert_pwup_after_clk_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwup_rst_n_o) |-> (clk_stop_o == 3'b000));

  assert_btn_after_pwup_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(btn_rst_n_o) |-> pwup_rst_n_o);

  assert_fields_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ro_wr_en_o |=> ($stable(cap_width_o) && $stable(cap_speed_o) && $stable(class_code_o)));

  assert_link_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_en_o) |-> (!ro_wr_en_o && btn_rst_n_o && perst_out_n_o));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

bind rp_boot_seq rp_boot_chk #(.HOLD_CYC(HOLD_CYC), .DEV_TYPE(DEV_TYPE)) u_chk (
  .clk(clk), .rst_n(rst_n), .done_o(done_o),
  .perst_in_n_o(perst_in_n_o), .perst_out_n_o(perst_out_n_o),
  .pwup_rst_n_o(pwup_rst_n_o), .btn_rst_n_o(btn_rst_n_o),
  .aux_pwr_det_o(aux_pwr_det_o), .clk_req_o(clk_req_o), .clk_stop_o(clk_stop_o),
  .dev_type_o(dev_type_o), .ro_wr_en_o(ro_wr_en_o),
  .cap_width_o(cap_width_o), .cap_speed_o(cap_speed_o),
  .class_code_o(class_code_o), .link_en_o(link_en_o)
);

// File: tb/sim_rp_boot_seq.sv
`timescale 1ns/1ps
module sim_rp_boot_seq;
  localparam int TPM = 4;
  localparam int HMS = 150;
  localparam int H   = TPM * HMS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;

  logic        done, pin, pout, pwup, btn, sel, aux, we, link;
  logic [2:0]  req, stp;
  logic [3:0]  dev, wid, spd;
  logic [23:0] cls;

  // expected model
  logic        e_done, e_pin, e_pout, e_pwup, e_btn, e_sel, e_aux, e_we, e_link;
  logic [2:0]  e_req, e_stp;
  logic [3:0]  e_dev, e_wid, e_spd;
  logic [23:0] e_cls;

  int vectors = 0;
  int errors  = 0;

  always #10 clk = ~clk;

  rp_boot_seq #(.TICKS_PER_MS(TPM), .HOLD_MS(HMS)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .done_o(done),
    .perst_in_n_o(pin), .perst_out_n_o(pout), .pwup_rst_n_o(pwup),
    .btn_rst_n_o(btn), .rst_sel_o(sel), .aux_pwr_det_o(aux),
    .clk_req_o(req), .clk_stop_o(stp), .dev_type_o(dev), .ro_wr_en_o(we),
    .cap_width_o(wid), .cap_speed_o(spd), .class_code_o(cls), .link_en_o(link)
  );

  task automatic model_reset();
    {e_done, e_pin, e_pout, e_pwup, e_btn, e_sel, e_aux, e_we, e_link} = '0;
    e_req = 3'b000; e_stp = 3'b111;
    e_dev = 4'd0; e_wid = 4'd0; e_spd = 4'd0; e_cls = 24'd0;
  endtask

  // apply the step whose effect is due at edge k after the start sample
  task automatic model_step(input int k);
    int m;
    m = k - (4 + H);
    e_done = 1'b0;
    if (k == 1) begin
      e_pin = 0; e_pout = 0; e_pwup = 0; e_btn = 0; e_sel = 1; e_aux = 0;
      e_req = 3'b000; e_stp = 3'b111;
    end
    if (k == 2) e_link = 0;
    if (k == 3) e_dev = 4'd4;
    case (m)
      0: e_pin = 1;
      1: e_pout = 1;
      2: e_aux = 1;
      3: e_req[0] = 1;  4: e_stp[0] = 0;
      5: e_req[1] = 1;  6: e_stp[1] = 0;
      7: e_req[2] = 1;  8: e_stp[2] = 0;
      9: e_pwup = 1;
      10: e_btn = 1;
      11: e_we = 1;
      12: e_wid = 4'd4;
      13: e_spd = 4'd2;
      14: e_cls = 24'h060400;
      15: e_we = 0;
      16: begin e_link = 1; e_done = 1; end
      default: ;
    endcase
  endtask

  function automatic string tag_of(input int k);
    int m;
    m = k - (4 + H);
    if (k <= 1) return "R2";
    if (k <= 3) return "R3";
    if (m <= 1) return "R4";
    if (m == 2) return "R5";
    if (m <= 8) return "R6";
    if (m <= 10) return "R7";
    if (m <= 15) return "R8";
    return "R9";
  endfunction

  task automatic compare(input string tag);
    logic [50:0] got, exp;
    got = {pin, pout, pwup, btn, sel, aux, req, stp, dev, we, wid, spd, cls, link, done};
    exp = {e_pin, e_pout, e_pwup, e_btn, e_sel, e_aux, e_req, e_stp, e_dev, e_we,
           e_wid, e_spd, e_cls, e_link, e_done};
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s at %0t: got %h expected %h", tag, $time, got, exp);
    end
  endtask

  // one full series; poke injects start pulses while running (R10)
  task automatic run_seq(input bit poke, input string ovr);
    @(negedge clk) start = 1'b1;
    @(posedge clk);                       // edge 0 samples start
    for (int k = 1; k <= 22 + H; k++) begin
      @(posedge clk);
      model_step(k);
      @(negedge clk);
      compare(ovr != "" ? ovr : tag_of(k));
      start = poke && (k == 5 || k == H || k == 10 + H || k == 18 + H);
    end
    start = 1'b0;
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    compare("R1");                        // during reset
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare("R1");                        // idle after release
    run_seq(1'b0, "");                    // R2..R9 cycle by cycle
    repeat (4) begin @(negedge clk); compare("R9"); end
    run_seq(1'b1, "R10");                 // mid-run starts ignored
    run_seq(1'b0, "R11");                 // restart after completion
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule